// File: doc/BRIEF.md
# Stretchable External Data-Memory Cycle Generator

This block runs one external data-memory read or write on a multiplexed bus. The low address byte and the data share one bidirectional byte port. The high address byte has its own output port. An address latch enable pulse lets an external latch capture the low byte before the shared port is turned around for data.

A 3-bit stretch setting is held in a small configuration register. It sets how many machine cycles a transfer lasts, and how many clocks the read or write strobe stays active. Fast RAM can then run at the shortest setting, and slow memory-mapped peripherals get a longer strobe. No external wait logic is needed. One machine cycle is four clocks. The setting after reset is not the fastest one. The setting is copied when a request is accepted, so software can change it between transfers without disturbing a transfer that is running.

Top module: `xmem_stretch_cycle`

## Requirements
- R1: After reset the block is idle: `busy`=0, `done`=0, `ale`=0, `rd_n`=1, `wr_n`=1, `p0_oe`=0. The stretch register holds 1.
- R2: A transfer lasts 4*(S+2) clocks. S is the stretch value copied when the request is accepted. `busy` is high for exactly those clocks, starting the clock after acceptance.
- R3: The active-low strobe is low for 2 clocks when S=0, 4 clocks when S=1, 8 clocks when S=2, and 4*S clocks when S is 3 to 7.
- R4: The strobe goes low on the fifth clock of the transfer (clock index 4, counting from 0).
- R5: `ale` is high on clock indices 0 and 1 only. On indices 0 to 2, `p0_oe`=1 and `p0_out` carries `addr[7:0]`. `p2_out` carries `addr[15:8]` on every clock of the transfer.
- R6: For a read (`rd_nwr`=1), `p0_oe` is 0 from index 3 to the end of the transfer. `rdata` takes the value of `p0_in` on the clock edge that ends the last low clock of `rd_n`.
- R7: For a write (`rd_nwr`=0), `p0_oe`=1 and `p0_out`=`wdata` from index 3 through the first clock after `wr_n` returns high.
- R8: `done` is high for one clock, on the last clock of the transfer. `busy` is 0 on the clock after it.
- R9: A request that arrives while `busy` is high is ignored. It starts no transfer and does not change the address, data or direction of the transfer that is running.
- R10: A stretch write (`cfg_we`) made during a transfer leaves that transfer's timing unchanged. The next transfer uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write enable for the stretch register |
| cfg_stretch | input | 3 | New stretch value |
| req | input | 1 | Start request, taken only when idle |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| addr | input | ADDR_W | Transfer address |
| wdata | input | DATA_W | Write data |
| p0_in | input | DATA_W | Value seen on the shared port |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| p0_out | output | DATA_W | Drive value for the shared port |
| p0_oe | output | 1 | Output enable for the shared port |
| p2_out | output | ADDR_W-DATA_W | High address byte |
| rdata | output | DATA_W | Captured read data |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-clock end-of-transfer pulse |

## Verification
The hardest point to observe from the ports is the exact edge at which read data is sampled. If the memory model returned a steady value, an off-by-one sample point would go unnoticed. The bench memory model therefore drives `p0_in` with a base byte XORed with the number of strobe clocks already seen. The captured value then shows which strobe clock was sampled, for every stretch value tested. The stretch register is also rewritten while a transfer is running, and a request is raised while busy. Both are checked against the timing of the transfer that is in flight.

// File: rtl/xmem_stretch_cycle.sv
module xmem_stretch_cycle #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [2:0] RESET_STRETCH = 3'd1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [2:0]               cfg_stretch,
  input  logic                     req,
  input  logic                     rd_nwr,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [DATA_W-1:0]        p0_in,
  output logic                     ale,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic [DATA_W-1:0]        p0_out,
  output logic                     p0_oe,
  output logic [ADDR_W-DATA_W-1:0] p2_out,
  output logic [DATA_W-1:0]        rdata,
  output logic                     busy
  ,output logic                    done
);

  localparam int CW = 6;
  localparam logic [CW-1:0] STB_START = CW'(4);
  localparam logic [CW-1:0] ADDR_LAST = CW'(2);
  localparam logic [CW-1:0] ALE_END   = CW'(2);

  function automatic logic [CW-1:0] stb_clks(input logic [2:0] s);
    case (s)
      3'd0:    stb_clks = CW'(2);
      3'd1:    stb_clks = CW'(4);
      3'd2:    stb_clks = CW'(8);
      default: stb_clks = {1'b0, s, 2'b00};
    endcase
  endfunction

  logic              busy_q;
  logic [CW-1:0]     cnt;
  logic [2:0]        cfg_q, st_q;
  logic              rd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wd_q, rdata_q;

  wire [CW-1:0] last_cnt = {1'b0, st_q, 2'b00} + CW'(7);
  wire [CW-1:0] stb_w    = stb_clks(st_q);
  wire [CW-1:0] stb_end  = STB_START + stb_w;
  wire strobe_on = busy_q && cnt >= STB_START && cnt < stb_end;
  wire addr_ph   = busy_q && cnt <= ADDR_LAST;
  wire wdat_ph   = busy_q && !rd_q && cnt > ADDR_LAST && cnt <= stb_end;
  wire start     = !busy_q && req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= RESET_STRETCH;
    else if (cfg_we) cfg_q <= cfg_stretch;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt    <= '0;
      st_q   <= RESET_STRETCH;
      rd_q   <= 1'b0;
      addr_q <= '0;
      wd_q   <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt    <= '0;
      st_q   <= cfg_q;
      rd_q   <= rd_nwr;
      addr_q <= addr;
      wd_q   <= wdata;
    end else if (busy_q) begin
      if (cnt == last_cnt) begin
        busy_q <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else if (busy_q && rd_q && cnt == stb_end - CW'(1)) rdata_q <= p0_in;
  end

  assign ale    = busy_q && cnt < ALE_END;
  assign rd_n   = !(strobe_on && rd_q);
  assign wr_n   = !(strobe_on && !rd_q);
  assign p0_oe  = addr_ph || wdat_ph;
  assign p0_out = addr_ph ? addr_q[DATA_W-1:0] : wd_q;
  assign p2_out = addr_q[ADDR_W-1:DATA_W];
  assign rdata  = rdata_q;
  assign busy   = busy_q;
  assign done   = busy_q && cnt == last_cnt;

  logic [CW-1:0] chk_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chk_len <= '0;
    else if (!rd_n || !wr_n) chk_len <= chk_len + CW'(1);
    else chk_len <= '0;
  end

  a_r1_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
  a_r3_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt == stb_end) |-> chk_len == stb_w);
  a_r5_ale_drives_addr: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (p0_oe && rd_n && wr_n && p0_out == addr_q[DATA_W-1:0]));
  a_r6_read_port_released: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !p0_oe);
  a_r7_write_port_driven: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (p0_oe && p0_out == wd_q));
  a_r7_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $rose(wr_n)) |-> p0_oe);
  a_r8_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  a_r10_stretch_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(st_q));
  a_r9_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(p2_out));

endmodule

// File: tb/xmem_stretch_cycle_test.sv
module xmem_stretch_cycle_test;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, req = 0, rd_nwr = 0;
  logic [2:0] cfg_stretch = 0;
  logic [15:0] addr = 0;
  logic [7:0] wdata = 0, p0_in = 0;
  logic ale, rd_n, wr_n, p0_oe, busy, done;
  logic [7:0] p0_out, p2_out, rdata;

  always #4 clk = ~clk;

  xmem_stretch_cycle uut (.clk, .rst_n, .cfg_we, .cfg_stretch, .req, .rd_nwr,
    .addr, .wdata, .p0_in, .ale, .rd_n, .wr_n, .p0_out, .p0_oe, .p2_out,
    .rdata, .busy, .done);

  typedef struct packed { logic rd; logic [15:0] a; logic [7:0] wd; logic [7:0] base; logic [2:0] s; } item_t;
  item_t q[$];
  int tests = 0, fails = 0, pushed = 0, seen = 0;
  logic [2:0] shadow = 3'd1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0d expected=%0d", tag, act, exp); end
  endtask

  function automatic int width_of(input logic [2:0] s);
    if (s == 0) return 2;
    if (s == 1) return 4;
    if (s == 2) return 8;
    return 4 * int'(s);
  endfunction

  // monitor / scoreboard
  initial begin
    item_t cur;
    bit in_x = 0;
    int idx = 0, ale_n = 0, sn = 0, sfirst = -1, bad = 0, badp2 = 0;
    forever begin
      @(negedge clk);
      if (busy) begin
        if (!in_x) begin
          in_x = 1; idx = 0; ale_n = 0; sn = 0; sfirst = -1; bad = 0; badp2 = 0;
          seen++;
          if (q.size() == 0) begin check(0, "R9 unexpected transfer", 1, 0); cur = '0; end
          else cur = q.pop_front();
        end
        if (p2_out != cur.a[15:8]) badp2++;
        if (ale) begin
          ale_n++;
          if (idx > 1) bad++;
        end
        if (idx <= 2 && !(p0_oe && p0_out == cur.a[7:0])) bad++;
        if (cur.rd && idx >= 3 && p0_oe) bad++;
        if (!cur.rd && idx >= 3 && idx <= 4 + width_of(cur.s) && !(p0_oe && p0_out == cur.wd)) bad++;
        if (!rd_n || !wr_n) begin
          if (sfirst < 0) sfirst = idx;
          if (!rd_n) p0_in = cur.base ^ 8'(sn);
          sn++;
          if ((cur.rd && !wr_n) || (!cur.rd && !rd_n)) bad++;
        end
        if (done) begin
          check(idx + 1 == 4 * (int'(cur.s) + 2), "R2 transfer length", idx + 1, 4 * (int'(cur.s) + 2));
          check(sn == width_of(cur.s), "R3 strobe width", sn, width_of(cur.s));
          check(sfirst == 4, "R4 strobe start", sfirst, 4);
          check(ale_n == 2 && badp2 == 0, "R5 ale/high address", ale_n, 2);
          if (cur.rd) begin
            check(bad == 0, "R6 read port release", bad, 0);
            check(rdata == (cur.base ^ 8'(width_of(cur.s) - 1)), "R6 read sample edge",
                  rdata, cur.base ^ 8'(width_of(cur.s) - 1));
          end else
            check(bad == 0, "R7 write data window", bad, 0);
          in_x = 0;
          @(negedge clk);
          check(!busy && !done, "R8 done single pulse", busy, 0);
        end
        idx++;
      end else begin
        p0_in = 8'h00;
      end
    end
  end

  task automatic xfer(input bit rd, input logic [15:0] a, input logic [7:0] wd,
                      input logic [7:0] base, input int mode, input logic [2:0] news);
    item_t it;
    @(negedge clk);
    while (busy) @(negedge clk);
    req = 1; rd_nwr = rd; addr = a; wdata = wd;
    it.rd = rd; it.a = a; it.wd = wd; it.base = base; it.s = shadow;
    q.push_back(it); pushed++;
    @(negedge clk);
    req = 0;
    @(negedge clk);
    if (mode == 1) begin
      req = 1; rd_nwr = ~rd; addr = ~a; wdata = ~wd;
      @(negedge clk); req = 0;
    end else if (mode == 2) begin
      cfg_we = 1; cfg_stretch = news;
      @(negedge clk); cfg_we = 0; shadow = news;
    end
    while (busy) @(negedge clk);
  endtask

  task automatic set_stretch(input logic [2:0] s);
    @(negedge clk);
    cfg_we = 1; cfg_stretch = s;
    @(negedge clk);
    cfg_we = 0; shadow = s;
  endtask

  initial begin
    #1000000;
    check(0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !ale && rd_n && wr_n && !p0_oe, "R1 idle after reset", busy, 0);
    rst_n = 1;
    @(negedge clk);
    check(!busy && rd_n && wr_n && !p0_oe, "R1 idle after release", busy, 0);
    xfer(1, 16'h12A5, 8'h00, 8'h30, 0, 0);   // R1 default stretch 1
    xfer(0, 16'h3456, 8'hC3, 8'h00, 0, 0);
    for (int s = 0; s < 8; s++) begin
      set_stretch(3'(s));
      xfer(1, 16'(16'h8000 + s * 16'h0111), 8'h00, 8'(8'h40 + s), 0, 0);
      xfer(0, 16'(16'h0F00 + s * 16'h1001), 8'(8'h5A ^ s), 8'h00, 0, 0);
    end
    set_stretch(3'd2);
    xfer(1, 16'hBEEF, 8'h00, 8'h77, 1, 0);   // R9 request while busy
    xfer(0, 16'hCAFE, 8'h99, 8'h00, 1, 0);   // R9
    xfer(1, 16'h1357, 8'h00, 8'h11, 2, 3'd6); // R10 stretch written mid-transfer
    xfer(0, 16'h2468, 8'h66, 8'h00, 0, 0);    // R10 new value in effect
    xfer(1, 16'h0001, 8'h00, 8'hE0, 2, 3'd0); // R10
    xfer(1, 16'hFFFE, 8'h00, 8'h0F, 0, 0);
    repeat (4) @(negedge clk);
    check(seen == pushed && q.size() == 0, "R9 transfer count", seen, pushed);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule